// File: doc/BRIEF.md
# Go-Gated Event Time Stamper

This block keeps a wide free-running count of time-stamp ticks and copies that count into a holding register whenever an event is accepted. A tick normally comes from a divide-by-four enable taken from the 40 MHz system clock, which gives a 10 MHz time base. A configuration input can switch the tick source to an external clock pin instead. That pin is synchronized and reduced to one enable pulse per rising edge.

A shared run control governs every counter in a system. While it is low, no tick reaches the counter, and the counter can be zeroed by a hardware clear or by a software clear. When it goes high, all counters start from the same value and the same divider phase. The gated tick is driven out, so further counters elsewhere can follow the same time base.

The run control is handled by a two-state sequencer. `ST_HOLD` holds the counter still and allows clears. `ST_RUN` lets ticks through. The transition named *start* (`ST_HOLD` to `ST_RUN`) is taken on the first edge where `go_i` is high. The transition named *stop* (`ST_RUN` to `ST_HOLD`) is taken on the first edge where `go_i` is low.

Top module: `evt_stamper`

## Requirements
- R1: After reset the captured stamp reads 0, the counter is 0, `tick_o` is low and the sequencer is in `ST_HOLD`.
- R2: The sequencer takes *start* on an edge where `go_i` is high and *stop* on an edge where `go_i` is low. Ticks pass only in `ST_RUN`.
- R3: With the internal source (`use_ext_i` = 0), a tick occurs in every fourth cycle spent in `ST_RUN`. The first tick falls in the fourth such cycle, because the divider restarts on every *start*. A run of n cycles therefore adds floor(n/4).
- R4: In `ST_HOLD` the counter keeps its value for any number of cycles, whatever the tick source is doing.
- R5: `clr_i` or `sw_clr_i` sampled high in `ST_HOLD` sets the counter to 0. Either one sampled high in `ST_RUN` has no effect.
- R6: When `trig_i` or `latch_i` is sampled high, `stamp_o` takes the counter value on that edge. Otherwise `stamp_o` holds. A capture never alters the counter.
- R7: If a capture and a tick fall in the same cycle, `stamp_o` receives the value from before the increment, and the counter still advances by one.
- R8: With `use_ext_i` = 1, each rising edge of `ext_clk_i` in `ST_RUN` gives exactly one tick, two synchronizer edges later. The internal divider then contributes nothing.
- R9: `tick_o` is high for exactly the cycles whose following edge increments the counter.
- R10: The counter wraps from all ones to 0 with no indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Shared run control; low inhibits counting |
| use_ext_i | input | 1 | 1 selects the external clock as the tick source |
| ext_clk_i | input | 1 | External time-stamp clock, asynchronous |
| trig_i | input | 1 | Live trigger; captures the count |
| latch_i | input | 1 | Latch request; captures the count |
| clr_i | input | 1 | Hardware clear, honoured only while held |
| sw_clr_i | input | 1 | Software clear, honoured only while held |
| tick_o | output | 1 | Gated tick for distribution |
| stamp_o | output | CNT_W | Captured time stamp |

## Verification
Two functions can fall in the same cycle: the capture of the count and the increment of that count. The bench runs the internal divider up to its first tick and checks, by watching `tick_o`, that the tick is present. In that same cycle it raises `trig_i`, and it does the same with `latch_i` on the next tick. It judges the result three ways:
- the first stamp must read 0, the value before the increment;
- the second stamp must read 1;
- a final read after *stop* must show that both increments were still counted.

// File: rtl/stamper_pkg.sv
package stamper_pkg;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } stamp_state_e;

endpackage

// File: rtl/stamp_seq.sv
module stamp_seq
    import stamper_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    output logic run_o
);

    stamp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (go_i)  state_d = ST_RUN;   // start
            ST_RUN:  if (!go_i) state_d = ST_HOLD;  // stop
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HOLD;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run_o = 1'b1;
            default: run_o = 1'b0;
        endcase
    end

    // R2: start and stop follow the sampled run control
    a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |=> run_o);
    a_r2_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !go_i |=> !run_o);

endmodule

// File: rtl/stamp_tick.sv
module stamp_tick #(
    parameter int DIV_RATIO   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic use_ext_i,
    input  logic ext_clk_i,
    output logic tick_o
);

    localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

    logic int_tick;
    logic ext_edge;
    logic [SYNC_STAGES:0] sync_q;

    generate
        if (DIV_RATIO > 1) begin : g_div
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)               div_q <= '0;
                else if (!run_i)           div_q <= '0;
                else if (div_q == DIV_LAST) div_q <= '0;
                else                       div_q <= div_q + 1'b1;
            end

            assign int_tick = (div_q == DIV_LAST);

            // R3: internal ticks are never back to back
            a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (tick_o && !use_ext_i) |=> (!tick_o || use_ext_i));
        end else begin : g_nodiv
            assign int_tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
    end

    assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    assign tick_o = run_i & (use_ext_i ? ext_edge : int_tick);

    // R8: one enable pulse per external rising edge
    a_r8_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_edge |=> !ext_edge);

endmodule

// File: rtl/stamp_count.sv
module stamp_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             cap_i,
    output logic [CNT_W-1:0] stamp_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
        else if (!run_i && clr_i) cnt_q <= '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stamp_o <= '0;
        else if (cap_i) stamp_o <= cnt_q;
    end

    // R4: no movement while held unless cleared
    a_r4_hold_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
    // R5: clear ignored while running
    a_r5_clr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && clr_i && !tick_i) |=> (cnt_q == $past(cnt_q)));
    // R5: clear honoured while held
    a_r5_clr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && clr_i) |=> (cnt_q == '0));
    // R6: stamp holds without a capture
    a_r6_stamp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_i |=> $stable(stamp_o));
    // R7: coincident capture sees the pre-increment value
    a_r7_pre_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_i && run_i && tick_i) |=> (cnt_q == CNT_W'(stamp_o + 1'b1)));

endmodule

// File: rtl/evt_stamper.sv
module evt_stamper #(
    parameter int CNT_W       = 64,
    parameter int DIV_RATIO   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    input  logic             use_ext_i,
    input  logic             ext_clk_i,
    input  logic             trig_i,
    input  logic             latch_i,
    input  logic             clr_i,
    input  logic             sw_clr_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] stamp_o
);

    logic run;
    logic tick;

    stamp_seq u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (go_i),
        .run_o  (run)
    );

    stamp_tick #(
        .DIV_RATIO   (DIV_RATIO),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .use_ext_i (use_ext_i),
        .ext_clk_i (ext_clk_i),
        .tick_o    (tick)
    );

    stamp_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .tick_i  (tick),
        .clr_i   (clr_i | sw_clr_i),
        .cap_i   (trig_i | latch_i),
        .stamp_o (stamp_o)
    );

    assign tick_o = tick;

    // R2/R9: the exported tick only appears while the run control was high
    a_r9_tick_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> $past(go_i));

endmodule

// File: tb/sim_evt_stamper.sv
module sim_evt_stamper;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic go = 1'b0, use_ext = 1'b0, ext_clk = 1'b0;
    logic trig = 1'b0, latch = 1'b0, clr = 1'b0, sw_clr = 1'b0;
    logic tick0, tick1;
    logic [63:0] stamp0;
    logic [2:0]  stamp1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int ticks;

    // entries: {run cycles, expected count}
    localparam logic [31:0] RUN_TBL [0:6] = '{
        {16'd0,  16'd0}, {16'd3,  16'd0}, {16'd4,  16'd1}, {16'd7, 16'd1},
        {16'd8,  16'd2}, {16'd13, 16'd3}, {16'd41, 16'd10}
    };

    always #10 clk = ~clk;

    evt_stamper u0 (
        .clk_i(clk), .rst_ni(rst_ni), .go_i(go), .use_ext_i(use_ext),
        .ext_clk_i(ext_clk), .trig_i(trig), .latch_i(latch), .clr_i(clr),
        .sw_clr_i(sw_clr), .tick_o(tick0), .stamp_o(stamp0)
    );

    evt_stamper #(.CNT_W(3)) u1 (
        .clk_i(clk), .rst_ni(rst_ni), .go_i(go), .use_ext_i(use_ext),
        .ext_clk_i(ext_clk), .trig_i(trig), .latch_i(latch), .clr_i(clr),
        .sw_clr_i(sw_clr), .tick_o(tick1), .stamp_o(stamp1)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_hold();
        go = 1'b0; cyc();
        clr = 1'b1; cyc();
        clr = 1'b0;
    endtask

    task automatic run_n(input int n);
        ticks = 0;
        go = 1'b1;
        repeat (n) begin
            cyc();
            if (tick0) ticks++;
        end
        go = 1'b0; cyc();
    endtask

    task automatic latch_read();
        latch = 1'b1; cyc();
        latch = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1: reset state
        check("R1 stamp", stamp0, 64'd0);
        check("R1 tick", {63'd0, tick0}, 64'd0);
        rst_ni = 1'b1;
        cyc();

        // R3/R9: table of run lengths
        for (int i = 0; i < 7; i++) begin
            clear_hold();
            run_n(int'(RUN_TBL[i][31:16]));
            check("R9 tick count", 64'(ticks), 64'(RUN_TBL[i][15:0]));
            latch_read();
            check("R3 run count", stamp0, 64'(RUN_TBL[i][15:0]));
        end

        // R4: held counter stays still
        ticks = 0;
        repeat (12) begin cyc(); if (tick0) ticks++; end
        check("R4 no tick in hold", 64'(ticks), 64'd0);
        latch_read();
        check("R4 held value", stamp0, 64'd10);

        // R5: clear ignored while running, honoured while held
        clear_hold();
        clr = 1'b1;
        run_n(8);
        clr = 1'b0;
        latch_read();
        check("R5 clear ignored in run", stamp0, 64'd2);
        sw_clr = 1'b1; cyc(); sw_clr = 1'b0;
        latch_read();
        check("R5 sw clear in hold", stamp0, 64'd0);

        // R3: divider restarts on each start
        clear_hold();
        run_n(3);
        run_n(3);
        latch_read();
        check("R3 divider restart", stamp0, 64'd0);

        // R7: capture in the tick cycle
        clear_hold();
        go = 1'b1;
        repeat (4) cyc();
        check("R9 first tick", {63'd0, tick0}, 64'd1);
        trig = 1'b1; cyc(); trig = 1'b0;
        check("R7 trig pre-increment", stamp0, 64'd0);
        repeat (3) cyc();
        check("R9 second tick", {63'd0, tick0}, 64'd1);
        latch = 1'b1; cyc(); latch = 1'b0;
        check("R7 latch pre-increment", stamp0, 64'd1);
        go = 1'b0; cyc();
        latch_read();
        check("R6 count kept", stamp0, 64'd2);
        repeat (2) cyc();
        check("R6 stamp holds", stamp0, 64'd2);

        // R8: external source
        clear_hold();
        use_ext = 1'b1;
        go = 1'b1;
        repeat (2) cyc();
        for (int k = 0; k < 5; k++) begin
            ext_clk = 1'b1; repeat (3) cyc();
            ext_clk = 1'b0; repeat (3) cyc();
        end
        repeat (4) cyc();
        go = 1'b0; cyc();
        latch_read();
        check("R8 external edges", stamp0, 64'd5);
        clear_hold();
        for (int k = 0; k < 3; k++) begin
            ext_clk = 1'b1; repeat (3) cyc();
            ext_clk = 1'b0; repeat (3) cyc();
        end
        latch_read();
        check("R4 external edges in hold", stamp0, 64'd0);
        use_ext = 1'b0;

        // R10: wrap in the narrow instance
        clear_hold();
        run_n(36);
        latch_read();
        check("R10 wrap narrow", 64'(stamp1), 64'd1);
        check("R10 wide reference", stamp0, 64'd9);

        done = 1;
        report();
        $finish;
    end

endmodule